// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers four interrupt sources into one request line for a small processor core. Two come from external pins, which are synchronized and edge-detected. Two are single-cycle overflow pulses from on-chip timers. Each event sets a sticky request flag, whether or not that source is enabled. Software enables sources one by one, and a global enable qualifies the whole set. When any flag is pending and its enable is set while the global enable is on, the block raises a registered request toward the core. It also presents a fixed service vector.

When the core accepts the request it pulses an acknowledge, and the block drops the global enable so that nothing else can interrupt the handler. A return strobe at the end of the handler sets the global enable again. Software reaches the per-source enables, the request flags, the edge mode of the first pin and the global enable through one write port and one read port. Flags are cleared by writing zeros.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, the enable register, the request flags, the edge mode and the global enable all read 0, and `irq_req` is 0.
- R2: `irq_vector` always presents 16'h0008 once reset has been applied.
- R3: Flag bit positions are bit0 = first pin, bit1 = second pin, bit2 = timer 0 (`tmr_ovf[0]`), bit3 = timer 1 (`tmr_ovf[1]`). A source's event sets its flag even when that source's enable bit is 0.
- R4: `irq_req` is 1 on the clock edge after a cycle in which the global enable is 1 and at least one bit of (flags AND enables) is 1. Otherwise it is 0.
- R5: An `irq_ack` pulse clears the global enable on the next edge, so `irq_req` falls one edge later.
- R6: An `irq_ret` pulse sets the global enable. If `irq_ack` is high in the same cycle, the acknowledge wins and the global enable ends at 0.
- R7: Writing the request register (`wr_sel` = 1) clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. An event in the same cycle keeps its flag set.
- R8: The second pin (`ext_pin[1]`) sets bit1 only on a falling edge. A rising edge has no effect.
- R9: The first pin's edge mode (2 bits) selects the trigger: 01 = rising, 11 = both edges, 00 and 10 = falling.
- R10: A pin level first sampled at edge k sets its flag at edge k+2 (two synchronizer flops, then edge detection).
- R11: Register select codes for `wr_sel` and `rd_sel` are 0 = enables, 1 = request flags, 2 = edge mode in bits [1:0], 3 = global enable in bit 0. `rd_data` shows the selected register one edge after `rd_sel` is applied, with unused bits 0.
- R12: A write with `wr_en` high loads the selected enable, edge-mode or global-enable register on the next edge. The acknowledge and return strobes take precedence over a write of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 4 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 4 | Registered read data |
| ext_pin | input | 2 | Raw external interrupt pins (idle high) |
| tmr_ovf | input | 2 | Timer overflow pulses |
| irq_ack | input | 1 | Core accepted the interrupt |
| irq_ret | input | 1 | Core returned from the handler |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_vector | output | 16 | Service vector address |

## Verification
The properties assume that the timer inputs are clean one-cycle pulses that are sampled on clock edges. They also assume that acknowledge and return arrive as strobes, while the pins may toggle freely because the block synchronizes them itself. The stimulus changes every input only at the falling clock edge. It holds each pin level for several cycles so that the synchronizer always sees a settled edge. It drives acknowledge and return only as single-cycle pulses, including one cycle where both are high together. Expectations on flags and the request line are timed from the stated latencies of two synchronizer stages, one flag register and one output register.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_PINS = 2;
  localparam int NUM_TMR  = 2;
  localparam int NUM_SRC  = NUM_PINS + NUM_TMR;
  localparam int MODE_W   = 2;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_REQ  = 2'd1,
    SEL_EDGE = 2'd2,
    SEL_GIE  = 2'd3
  } reg_sel_e;

  localparam logic [MODE_W-1:0] MODE_RISE = 2'b01;
  localparam logic [MODE_W-1:0] MODE_BOTH = 2'b11;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_en,
  input  logic [N-1:0] keep_mask,
  output logic [N-1:0] req
);
  logic [N-1:0] req_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        req_q[i] <= 1'b0;
      else if (evt[i])
        req_q[i] <= 1'b1;
      else if (clr_en && !keep_mask[i])
        req_q[i] <= 1'b0;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  input  logic ret,
  input  logic sw_wr,
  input  logic sw_val,
  output logic gie
);
  logic gie_q;

  always_ff @(posedge clk) begin
    if (rst)        gie_q <= 1'b0;
    else if (ack)   gie_q <= 1'b0;
    else if (ret)   gie_q <= 1'b1;
    else if (sw_wr) gie_q <= sw_val;
  end

  assign gie = gie_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int               VEC_W       = 16,
  parameter logic [VEC_W-1:0] VEC_ADDR    = 16'h0008,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [NUM_SRC-1:0]  wr_data,
  input  logic [1:0]          rd_sel,
  output logic [NUM_SRC-1:0]  rd_data,
  input  logic [NUM_PINS-1:0] ext_pin,
  input  logic [NUM_TMR-1:0]  tmr_ovf,
  input  logic                irq_ack,
  input  logic                irq_ret,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vector
);
  reg_sel_e wsel, rsel;
  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);

  logic [NUM_PINS-1:0] pin_rise, pin_fall;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (ext_pin[p]),
      .rise(pin_rise[p]),
      .fall(pin_fall[p])
    );
  end

  logic [MODE_W-1:0]  mode_q;
  logic [NUM_SRC-1:0] en_q;
  logic               first_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      if (wsel == SEL_EDGE) mode_q <= wr_data[MODE_W-1:0];
      if (wsel == SEL_EN)   en_q   <= wr_data;
    end
  end

  always_comb begin
    case (mode_q)
      MODE_RISE: first_evt = pin_rise[0];
      MODE_BOTH: first_evt = pin_rise[0] | pin_fall[0];
      default:   first_evt = pin_fall[0];
    endcase
  end

  logic [NUM_SRC-1:0] evt;
  assign evt = {tmr_ovf, pin_fall[1], first_evt};

  logic [NUM_SRC-1:0] req_q;
  irq_req_bank #(.N(NUM_SRC)) u_req (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .clr_en   (wr_en && (wsel == SEL_REQ)),
    .keep_mask(wr_data),
    .req      (req_q)
  );

  logic gie_q;
  irq_gie_ctl u_gie (
    .clk   (clk),
    .rst   (rst),
    .ack   (irq_ack),
    .ret   (irq_ret),
    .sw_wr (wr_en && (wsel == SEL_GIE)),
    .sw_val(wr_data[0]),
    .gie   (gie_q)
  );

  logic [NUM_SRC-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rsel)
      SEL_EN:   rd_mux = en_q;
      SEL_REQ:  rd_mux = req_q;
      SEL_EDGE: rd_mux[MODE_W-1:0] = mode_q;
      SEL_GIE:  rd_mux[0] = gie_q;
      default:  rd_mux = '0;
    endcase
  end

  logic [NUM_SRC-1:0] rd_q;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
      vec_q <= VEC_ADDR;
    end else begin
      rd_q  <= rd_mux;
      irq_q <= gie_q & (|(req_q & en_q));
      vec_q <= VEC_ADDR;
    end
  end

  assign rd_data    = rd_q;
  assign irq_req    = irq_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               irq_ack,
  input logic               irq_ret,
  input logic [NUM_TMR-1:0] tmr_ovf,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [NUM_SRC-1:0] wr_data,
  input logic               gie,
  input logic [NUM_SRC-1:0] req,
  input logic [NUM_SRC-1:0] en,
  input logic               irq_req
);
  p_ack_clears_gie_r5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !gie);

  p_ret_sets_gie_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && !irq_ack) |=> gie);

  p_irq_gated_r4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(gie) && ($past(req & en) != '0)));

  p_tmr0_latch_r3: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf[0] |=> req[2]);

  p_tmr1_latch_r3: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf[1] |=> req[3]);

  p_clear_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1 && !wr_data[2] && !tmr_ovf[0]) |=> !req[2]);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq_ack(irq_ack),
  .irq_ret(irq_ret),
  .tmr_ovf(tmr_ovf),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .gie    (gie_q),
  .req    (req_q),
  .en     (en_q),
  .irq_req(irq_req)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [3:0]  wr_data = 4'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [3:0]  rd_data;
  logic [1:0]  ext_pin = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vector;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          kind;   // 0 rd_data, 1 irq_req, 2 irq_vector
    logic [15:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare items that have come due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {12'd0, rd_data};
        1:       act = {15'd0, irq_req};
        default: act = irq_vector;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [15:0] exp, input int dly, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.due = cyc + dly; it.tag = tag;
    // keep queue ordered by due cycle
    if (q.size() == 0 || q[$].due <= it.due) q.push_back(it);
    else begin
      int pos = 0;
      while (q[pos].due <= it.due) pos++;
      q.insert(pos, it);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 4'd0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [3:0] exp, input string tag);
    rd_sel = sel;
    push(0, {12'd0, exp}, 1, tag);
    @(negedge clk);
  endtask

  task automatic pin_set(input int idx, input logic v);
    ext_pin[idx] = v;
    tick(5);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 / R11 reset state
    push(1, 16'd0, 1, "R1 irq_req after reset");
    push(2, 16'h0008, 1, "R2 vector");
    rd(2'd0, 4'd0, "R1 enables reset");
    rd(2'd1, 4'd0, "R1 flags reset");
    rd(2'd2, 4'd0, "R1 edge mode reset");
    rd(2'd3, 4'd0, "R1 gie reset");

    // R3: timer 0 event latches with enable 0
    tmr_ovf = 2'b01; tick(1); tmr_ovf = 2'b00;
    rd(2'd1, 4'b0100, "R3 flag without enable");
    push(1, 16'd0, 1, "R4 no request while disabled");
    tick(1);

    // R12 / R4: enable and global enable
    wr(2'd0, 4'b0100);
    wr(2'd3, 4'b0001);
    push(1, 16'd1, 1, "R4 request asserted");
    rd(2'd0, 4'b0100, "R12 enable write");
    rd(2'd3, 4'b0001, "R12 gie write");

    // R5: acknowledge
    irq_ack = 1'b1;
    push(1, 16'd1, 1, "R5 request one edge after ack");
    push(1, 16'd0, 2, "R5 request drops");
    tick(1); irq_ack = 1'b0; tick(1);
    rd(2'd3, 4'd0, "R5 gie cleared");

    // R6: return
    irq_ret = 1'b1;
    push(1, 16'd0, 1, "R6 request still low");
    push(1, 16'd1, 2, "R6 request back");
    tick(1); irq_ret = 1'b0; tick(1);
    rd(2'd3, 4'd1, "R6 gie set");
    irq_ack = 1'b1; irq_ret = 1'b1; tick(1); irq_ack = 1'b0; irq_ret = 1'b0;
    rd(2'd3, 4'd0, "R6 ack wins over return");

    // R7: clear by writing zero
    wr(2'd1, 4'b1011);
    rd(2'd1, 4'd0, "R7 flag cleared");
    tmr_ovf = 2'b10; tick(1); tmr_ovf = 2'b00;
    rd(2'd1, 4'b1000, "R3 timer1 flag");
    wr(2'd1, 4'b1111);
    rd(2'd1, 4'b1000, "R7 writing ones keeps");
    tmr_ovf = 2'b10; wr(2'd1, 4'b0000); tmr_ovf = 2'b00;
    rd(2'd1, 4'b1000, "R7 event wins over clear");
    wr(2'd1, 4'b0000);
    rd(2'd1, 4'b0000, "R7 clear all");

    // R8: second pin falling only
    pin_set(1, 1'b0);
    rd(2'd1, 4'b0010, "R8 falling sets");
    wr(2'd1, 4'd0);
    pin_set(1, 1'b1);
    rd(2'd1, 4'b0000, "R8 rising ignored");

    // R9: first pin edge modes
    pin_set(0, 1'b0);
    rd(2'd1, 4'b0001, "R9 mode 00 falling");
    wr(2'd1, 4'd0);
    pin_set(0, 1'b1);
    rd(2'd1, 4'b0000, "R9 mode 00 rising ignored");
    wr(2'd2, 4'b0001);
    rd(2'd2, 4'b0001, "R11 edge mode readback");
    pin_set(0, 1'b0);
    rd(2'd1, 4'b0000, "R9 mode 01 falling ignored");
    pin_set(0, 1'b1);
    rd(2'd1, 4'b0001, "R9 mode 01 rising");
    wr(2'd1, 4'd0);
    wr(2'd2, 4'b0011);
    pin_set(0, 1'b0);
    rd(2'd1, 4'b0001, "R9 mode 11 falling");
    wr(2'd1, 4'd0);
    pin_set(0, 1'b1);
    rd(2'd1, 4'b0001, "R9 mode 11 rising");
    wr(2'd1, 4'd0);
    wr(2'd2, 4'b0010);
    pin_set(0, 1'b0);
    rd(2'd1, 4'b0001, "R9 mode 10 falling");
    wr(2'd1, 4'd0);
    pin_set(0, 1'b1);
    rd(2'd1, 4'b0000, "R9 mode 10 rising ignored");

    // R10: synchronizer latency seen on the request line
    wr(2'd0, 4'b0001);
    wr(2'd3, 4'b0001);
    tick(2);
    ext_pin[0] = 1'b0;
    push(1, 16'd0, 3, "R10 no request before flag");
    push(1, 16'd1, 4, "R10 request after sync");
    tick(6);
    push(2, 16'h0008, 1, "R2 vector steady");
    tick(2);
    done = 1'b1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule